// File: doc/BRIEF.md
# I2C SCL Unstick Sequencer

This block frees an I2C bus that a slave device keeps busy. It watches two failure indications from the surrounding controller logic. The first is a timeout of a bus-busy wait, which is counted while the bus stays busy. The second is a transfer that never completed. When recovery is warranted, the block asks the controller to answer with NACK. It then takes the SCL pin away from the controller and toggles it directly through a fixed train of full clock pulses, timed by a shared timebase tick. Finally it gives the pin back and fires a reset pulse that makes the controller reinitialise itself.

The SCL pad mux is expected to select `scl_ovr_lvl` whenever `scl_ovr_en` is high. At all other times the controller alone drives SCL. Each half-period lasts `HALF_TICKS` timebase ticks. With a 1 MHz tick and the default of 25, each half-period is 25 µs. `done` pulses once for each completed recovery.

Top module: `scl_unstick`

## Requirements
- R1: While reset is held and in the first cycle after it, `scl_ovr_en`, `nack_req`, `ctrl_rst` and `done` are 0 and `scl_ovr_lvl` is 1.
- R2: While idle with `bus_busy` high, each `bb_timeout` pulse is counted. When `bb_timeout` arrives with `BB_LIMIT` (default 3) timeouts already counted, recovery starts in the next cycle and the count returns to zero.
- R3: While idle, a cycle with `bus_busy` low clears the timeout count, and a `bb_timeout` in that cycle is not counted.
- R4: While idle, `xfer_timeout` starts recovery in the next cycle whatever the count is, and the count returns to zero.
- R5: The first cycle of a recovery has `nack_req` high for exactly that one cycle, with `scl_ovr_en` low. The override starts in the following cycle.
- R6: During the pulse phase, `scl_ovr_en` stays high and `scl_ovr_lvl` alternates high then low. The phase holds exactly 2×`PULSES` halves (default 10 pulses), starting with a high half.
- R7: Each half ends at the clock edge that consumes its `HALF_TICKS`-th tick. Exactly `HALF_TICKS` tick cycles fall inside every half.
- R8: `scl_ovr_en` is 0 in every cycle outside the pulse phase, and `scl_ovr_lvl` is 1 whenever `scl_ovr_en` is 0.
- R9: The cycle after the last low half has `ctrl_rst` high for one cycle with `scl_ovr_en` low. The next cycle has `done` high for one cycle, and the block is then idle.
- R10: Triggers that arrive from the NACK cycle through the `done` cycle are ignored. They neither start a second recovery nor change the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy | input | 1 | Controller reports the bus as busy |
| bb_timeout | input | 1 | One-cycle pulse: a bus-busy wait timed out |
| xfer_timeout | input | 1 | One-cycle pulse: a transfer did not complete in time |
| tick | input | 1 | Timebase tick, one cycle wide |
| scl_ovr_en | output | 1 | SCL pin taken from the controller |
| scl_ovr_lvl | output | 1 | Level driven on SCL while overriding |
| nack_req | output | 1 | Request that the controller answer with NACK |
| ctrl_rst | output | 1 | One-cycle controller reset/reinitialise pulse |
| done | output | 1 | One-cycle pulse when a recovery finishes |

## Verification
Two functions can fall in the same cycle. In the first, a transfer timeout coincides with the bus-busy timeout that would itself reach the limit. The bench provokes this directly, then requires a single start in the next cycle and a count of zero afterwards. In the second, a new trigger coincides with the `done` cycle of a running recovery, or with the idle-clearing of the count. Random stimulus keeps triggers flowing while recoveries run. A per-cycle model built from the requirements then judges whether a start should follow, and any extra `nack_req` is flagged.

// File: rtl/scl_unstick_pkg.sv
package scl_unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NACK,
        ST_HIGH,
        ST_LOW,
        ST_RST,
        ST_DONE
    } unstick_state_e;

    typedef struct packed {
        logic ovr_en;
        logic ovr_lvl;
        logic nack;
        logic crst;
        logic fin;
    } unstick_out_t;

    function automatic unstick_out_t decode_state(unstick_state_e st);
        unstick_out_t o;
        o = '{ovr_en: 1'b0, ovr_lvl: 1'b1, nack: 1'b0, crst: 1'b0, fin: 1'b0};
        case (st)
            ST_NACK: o.nack = 1'b1;
            ST_HIGH: o.ovr_en = 1'b1;
            ST_LOW: begin
                o.ovr_en  = 1'b1;
                o.ovr_lvl = 1'b0;
            end
            ST_RST:  o.crst = 1'b1;
            ST_DONE: o.fin = 1'b1;
            default: ;
        endcase
        return o;
    endfunction

    function automatic logic in_pulse_phase(unstick_state_e st);
        return (st == ST_HIGH) || (st == ST_LOW);
    endfunction

endpackage

// File: rtl/scl_unstick_qualify.sv
module scl_unstick_qualify #(
    parameter int BB_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic bus_busy,
    input  logic bb_timeout,
    input  logic xfer_timeout,
    output logic start
);
    localparam int CW = $clog2(BB_LIMIT + 1);

    logic [CW-1:0] bb_cnt;
    logic          at_limit;

    assign at_limit = (bb_cnt == CW'(BB_LIMIT));
    assign start    = idle && (xfer_timeout || (bus_busy && bb_timeout && at_limit));

    always_ff @(posedge clk) begin
        if (rst) begin
            bb_cnt <= '0;
        end else if (idle) begin
            if (start || !bus_busy) begin
                bb_cnt <= '0;
            end else if (bb_timeout) begin
                bb_cnt <= bb_cnt + 1'b1;
            end
        end
    end

    // R2: the count never passes the limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        bb_cnt <= CW'(BB_LIMIT));

    // R3: an idle bus leaves the count at zero
    p_idle_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (idle && !bus_busy) |=> (bb_cnt == '0));

    // R10: count frozen while a recovery runs
    p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(bb_cnt));

endmodule

// File: rtl/scl_unstick_halftimer.sv
module scl_unstick_halftimer #(
    parameter int HALF_TICKS = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic half_end
);
    localparam int TW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

    logic [TW-1:0] tcnt;

    assign half_end = run && tick && (tcnt == TW'(HALF_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || half_end) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // R7: a half only ends on a tick
    p_end_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        half_end |-> tick);

    // R7: tick count stays below the half length
    p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
        tcnt <= TW'(HALF_TICKS - 1));

endmodule

// File: rtl/scl_unstick_fsm.sv
module scl_unstick_fsm
    import scl_unstick_pkg::*;
#(
    parameter int PULSES = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           half_end,
    output unstick_state_e state
);
    localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= ST_NACK;
                ST_NACK: begin
                    state <= ST_HIGH;
                    pcnt  <= '0;
                end
                ST_HIGH: if (half_end) state <= ST_LOW;
                ST_LOW: begin
                    if (half_end) begin
                        if (pcnt == PW'(PULSES - 1)) begin
                            state <= ST_RST;
                        end else begin
                            state <= ST_HIGH;
                            pcnt  <= pcnt + 1'b1;
                        end
                    end
                end
                ST_RST:  state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: pulse index stays inside the train
    p_pcnt_range_r6: assert property (@(posedge clk) disable iff (rst)
        pcnt <= PW'(PULSES - 1));

    // R9: done is followed by idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/scl_unstick.sv
module scl_unstick
    import scl_unstick_pkg::*;
#(
    parameter int BB_LIMIT   = 3,
    parameter int PULSES     = 10,
    parameter int HALF_TICKS = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_busy,
    input  logic bb_timeout,
    input  logic xfer_timeout,
    input  logic tick,
    output logic scl_ovr_en,
    output logic scl_ovr_lvl,
    output logic nack_req,
    output logic ctrl_rst,
    output logic done
);
    unstick_state_e state;
    unstick_out_t   outs;
    logic           start;
    logic           half_end;
    logic           idle;
    logic           run;

    assign idle = (state == ST_IDLE);
    assign run  = in_pulse_phase(state);

    scl_unstick_qualify #(.BB_LIMIT(BB_LIMIT)) qual_i (
        .clk          (clk),
        .rst          (rst),
        .idle         (idle),
        .bus_busy     (bus_busy),
        .bb_timeout   (bb_timeout),
        .xfer_timeout (xfer_timeout),
        .start        (start)
    );

    scl_unstick_halftimer #(.HALF_TICKS(HALF_TICKS)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (tick),
        .half_end (half_end)
    );

    scl_unstick_fsm #(.PULSES(PULSES)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .half_end (half_end),
        .state    (state)
    );

    assign outs        = decode_state(state);
    assign scl_ovr_en  = outs.ovr_en;
    assign scl_ovr_lvl = outs.ovr_lvl;
    assign nack_req    = outs.nack;
    assign ctrl_rst    = outs.crst;
    assign done        = outs.fin;

    // R5: NACK request is followed by the override
    p_nack_then_ovr_r5: assert property (@(posedge clk) disable iff (rst)
        nack_req |=> (scl_ovr_en && scl_ovr_lvl && !nack_req));

    // R9: release of SCL coincides with the controller reset
    p_release_rst_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_ovr_en) |-> ctrl_rst);

    // R9: controller reset is followed by done
    p_rst_then_done_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_rst |=> (done && !ctrl_rst));

    // R8: no two phase pulses at once, and level high when not overriding
    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nack_req, ctrl_rst, done, scl_ovr_en}));
    p_lvl_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !scl_ovr_en |-> scl_ovr_lvl);

endmodule

// File: tb/scl_unstick_tb_top.sv
module scl_unstick_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BB_LIMIT   = 3;
    localparam int PULSES     = 10;
    localparam int HALF_TICKS = 25;
    localparam int MAX_CYCLES = 150000;

    localparam int M_IDLE  = 0;
    localparam int M_NACK  = 1;
    localparam int M_PULSE = 2;
    localparam int M_RST   = 3;
    localparam int M_DONE  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_busy = 1'b0, bb_timeout = 1'b0, xfer_timeout = 1'b0, tick = 1'b0;
    logic scl_ovr_en, scl_ovr_lvl, nack_req, ctrl_rst, done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int m_phase = M_IDLE;
    int bcnt = 0;
    int tcnt = 0;
    int halves = 0;
    int starts = 0;
    logic exp_lvl = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scl_unstick #(.BB_LIMIT(BB_LIMIT), .PULSES(PULSES), .HALF_TICKS(HALF_TICKS)) dut_i (
        .clk (clk), .rst (rst), .bus_busy (bus_busy), .bb_timeout (bb_timeout),
        .xfer_timeout (xfer_timeout), .tick (tick), .scl_ovr_en (scl_ovr_en),
        .scl_ovr_lvl (scl_ovr_lvl), .nack_req (nack_req), .ctrl_rst (ctrl_rst), .done (done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    function automatic bit predict_start(input bit idle_now, input int cnt,
                                         input bit busy, input bit bbt, input bit xt);
        return idle_now && (xt || (busy && bbt && cnt == BB_LIMIT));
    endfunction

    function automatic int next_count(input bit idle_now, input bit st, input int cnt,
                                      input bit busy, input bit bbt);
        if (!idle_now) return cnt;   // R10
        if (st || !busy) return 0;   // R2 R3 R4
        if (bbt) return cnt + 1;
        return cnt;
    endfunction

    // One cycle: check outputs at the negedge, then drive inputs and update the model.
    task automatic step(input bit busy, input bit bbt, input bit xt, input bit tk);
        bit idle_now;
        bit st;
        @(negedge clk);
        cycles++;
        idle_now = (m_phase == M_IDLE);
        // Output checks
        chk("R5", "nack_req", int'(nack_req), (m_phase == M_NACK) ? 1 : 0);
        chk("R8", "scl_ovr_en", int'(scl_ovr_en), (m_phase == M_PULSE) ? 1 : 0);
        chk("R9", "ctrl_rst", int'(ctrl_rst), (m_phase == M_RST) ? 1 : 0);
        chk("R9", "done", int'(done), (m_phase == M_DONE) ? 1 : 0);
        if (m_phase == M_PULSE) chk("R6", "scl_ovr_lvl", int'(scl_ovr_lvl), int'(exp_lvl));
        else chk("R8", "scl_ovr_lvl idle", int'(scl_ovr_lvl), 1);
        // Drive inputs for this cycle
        bus_busy = busy; bb_timeout = bbt; xfer_timeout = xt; tick = tk;
        // Advance model phase
        case (m_phase)
            M_NACK: begin
                m_phase = M_PULSE; tcnt = 0; halves = 0; exp_lvl = 1'b1;
            end
            M_PULSE: begin
                if (tk) tcnt++;
                if (tcnt == HALF_TICKS) begin   // R7
                    tcnt = 0; halves++; exp_lvl = ~exp_lvl;
                    if (halves == 2 * PULSES) m_phase = M_RST;   // R6
                end
            end
            M_RST:  m_phase = M_DONE;
            M_DONE: m_phase = M_IDLE;
            default: ;
        endcase
        st = predict_start(idle_now, bcnt, busy, bbt, xt);
        bcnt = next_count(idle_now, st, bcnt, busy, bbt);
        if (st) begin
            m_phase = M_NACK;
            starts++;
        end
    endtask

    task automatic run_to_idle(input bit busy);
        while (m_phase != M_IDLE) step(busy, 1'b0, 1'b0, ($urandom % 3) == 0);
        step(busy, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=%0d exp=0", MAX_CYCLES);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        // R1: reset state, with triggers and ticks applied during reset
        repeat (3) begin
            @(negedge clk);
            bus_busy = 1'b1; bb_timeout = 1'b1; xfer_timeout = 1'b1; tick = 1'b1;
        end
        @(negedge clk);
        chk("R1", "scl_ovr_en in reset", int'(scl_ovr_en), 0);
        chk("R1", "scl_ovr_lvl in reset", int'(scl_ovr_lvl), 1);
        chk("R1", "nack_req in reset", int'(nack_req), 0);
        chk("R1", "ctrl_rst in reset", int'(ctrl_rst), 0);
        chk("R1", "done in reset", int'(done), 0);
        bus_busy = 1'b0; bb_timeout = 1'b0; xfer_timeout = 1'b0; tick = 1'b0;
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0);   // R1: first cycle after reset checked in step

        // R2: three counted timeouts, a fourth starts recovery
        for (int i = 0; i < BB_LIMIT; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b0, 1'b1);
        end
        step(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2", "start after limit", starts, 1);
        // R10: triggers during the run are ignored
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, (i % 7) == 0, 1'b1);
        run_to_idle(1'b1);
        chk("R10", "single start while running", starts, 1);

        // R3: idle bus clears count; a timeout in that cycle is not counted
        for (int i = 0; i < BB_LIMIT; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < BB_LIMIT; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3", "no start after clearing", starts, 1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3", "start after recount", starts, 2);
        run_to_idle(1'b1);

        // R4: transfer timeout starts at once; R4 with same-cycle limit timeout
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R4", "xfer start", starts, 3);
        run_to_idle(1'b1);
        chk("R4", "count cleared after xfer start", bcnt, 0);
        for (int i = 0; i < BB_LIMIT; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R4", "coincident triggers one start", starts, 4);
        run_to_idle(1'b1);

        // R7: ticks every cycle, then sparse ticks
        step(1'b0, 1'b0, 1'b1, 1'b1);
        while (m_phase != M_IDLE) step(1'b1, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        while (m_phase != M_IDLE) step(1'b1, 1'b0, 1'b0, ($urandom % 8) == 0);
        chk("R7", "directed starts", starts, 6);

        // Random mix: triggers keep arriving during runs and at done
        for (int i = 0; i < 60000; i++) begin
            step(($urandom % 16) != 0, ($urandom % 20) == 0,
                 ($urandom % 500) == 0, ($urandom % 3) == 0);
        end
        run_to_idle(1'b1);
        chk("R9", "ends idle", m_phase, M_IDLE);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule